// File: doc/BRIEF.md
# Two-Level ALU Control with 32-bit ALU

This block is the arithmetic stage of a single-cycle processor datapath, together with the small control unit that sits next to it. The main instruction decoder is outside the block. It supplies a 2-bit operation class. The block combines that class with the 6-bit function field of an R-format instruction and derives a 4-bit ALU operation code. The function field matters only when the class marks an R-format instruction. Loads and stores always add. Branch-on-equal always subtracts.

The control unit uses minimized sum-of-products equations. These equations exploit the don't-care rows of the full truth table, so function-field values that are not listed can map to codes the ALU does not recognise. The ALU works on two 32-bit operands and returns a result and a zero flag. The branch logic uses the zero flag to test two operands for equality. The whole block is combinational.

Top module: `alu_unit`

## Requirements
- R1: Operation class 00 gives op_o = 0010 (add), for every value of funct_i.
- R2: Operation class 01 gives op_o = 0110 (subtract), for every value of funct_i.
- R3: Operation class 10 decodes funct_i as follows: 100000 gives 0010 (add), 100010 gives 0110 (subtract), 100100 gives 0000 (AND), 100101 gives 0001 (OR), and 101010 gives 0111 (set-on-less-than).
- R4: For all 256 combinations of class {a1,a0} and funct {f5..f0}, op_o equals {0, a0|(a1&f1), ~a1|~f2, a1&(f3|f0)}. Bit 3 of op_o is therefore never set by the control path.
- R5: Codes 0000, 0001, 0010 and 0110 produce a&b, a|b, a+b and a-b. Add and subtract wrap modulo 2^32 and raise no error.
- R6: Code 0111 returns 1 in bit 0 when a is less than b as signed two's-complement numbers, and 0 otherwise. Bits 31..1 of the result are always zero.
- R7: The ALU core decodes code 1100 as NOR and returns ~(a|b).
- R8: Any code other than the six listed gives a result of zero. For example, class 10 with funct 001000 gives code 0011 and a result of 0.
- R9: zero_o is 1 exactly when result_o is all zeros. In particular, a subtract with equal operands sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_class_i | input | 2 | Operation class from the main decoder |
| funct_i | input | 6 | Function field of the instruction |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| op_o | output | 4 | ALU operation code chosen by the control unit |
| result_o | output | 32 | ALU result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The zero flag and a subtract-based result appear in the same evaluation. In a branch compare, the difference and the equality test both come out of one pass.

The bench provokes this with directed equal-operand subtracts under class 01 and with R-format subtracts. It also runs set-on-less-than cases whose result is 0, which raise zero_o even though the operands differ. Each of these cases checks the result word and zero_o together against values that the bench computes itself.

Random operands are driven with every class and function pattern. This also reaches the unrecognised codes, where a forced zero result must also raise the flag.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned FUNCT_W = 6;
  localparam int unsigned CLASS_W = 2;
  localparam int unsigned OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  localparam logic [CLASS_W-1:0] CLS_MEM = 2'b00;
  localparam logic [CLASS_W-1:0] CLS_BR  = 2'b01;
  localparam logic [CLASS_W-1:0] CLS_REG = 2'b10;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [CLASS_W-1:0] alu_class_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output logic [OP_W-1:0]    op_o
);
  logic a1, a0;
  logic unused_funct_hi;

  assign a1 = alu_class_i[1];
  assign a0 = alu_class_i[0];
  // upper funct bits are don't-cares after minimization
  assign unused_funct_hi = ^funct_i[5:4];

  always_comb begin
    op_o    = '0;
    op_o[2] = a0 | (a1 & funct_i[1]);
    op_o[1] = ~a1 | ~funct_i[2];
    op_o[0] = a1 & (funct_i[3] | funct_i[0]);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o
);
  logic [W-1:0] sum, diff;
  logic         lt_s;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  assign lt_s = $signed(a_i) < $signed(b_i);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_ADD:  res_o = sum;
      OP_SUB:  res_o = diff;
      OP_SLT:  res_o = {{(W-1){1'b0}}, lt_s};
      OP_NOR:  res_o = ~(a_i | b_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_zero.sv
module alu_zero #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res_i,
  output logic         zero_o
);
  assign zero_o = ~|res_i;
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
(
  input  logic [CLASS_W-1:0] alu_class_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [DATA_W-1:0]  op_a_i,
  input  logic [DATA_W-1:0]  op_b_i,
  output logic [OP_W-1:0]    op_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               zero_o
);
  logic [OP_W-1:0] op;

  alu_ctrl u_ctrl (
    .alu_class_i(alu_class_i),
    .funct_i    (funct_i),
    .op_o       (op)
  );

  alu_core #(.W(DATA_W)) u_core (
    .a_i  (op_a_i),
    .b_i  (op_b_i),
    .op_i (op),
    .res_o(result_o)
  );

  alu_zero #(.W(DATA_W)) u_zero (
    .res_i (result_o),
    .zero_o(zero_o)
  );

  assign op_o = op;

  always_comb begin
    if (alu_class_i == CLS_MEM) AST_MEM_ADD: assert (op == OP_ADD);                           // R1
    if (alu_class_i == CLS_BR)  AST_BRANCH_SUB: assert (op == OP_SUB);                        // R2
    AST_CTRL_C3_LOW: assert (op[3] == 1'b0);                                                  // R4
    if (op == OP_SLT) AST_SLT_FORM: assert (result_o[DATA_W-1:1] == '0);                      // R6
    if (op == OP_SUB && op_a_i == op_b_i) AST_EQ_ZERO: assert (zero_o);                       // R9
  end
endmodule

// File: tb/alu_unit_tb.sv
module alu_unit_tb;
  import alu_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  cls;
  logic [5:0]  fn;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic [31:0] res;
  logic        zero;

  logic [31:0] ca, cb, cres;
  logic [3:0]  cop;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  alu_unit u_dut (
    .alu_class_i(cls), .funct_i(fn), .op_a_i(a), .op_b_i(b),
    .op_o(op), .result_o(res), .zero_o(zero)
  );

  alu_core #(.W(32)) u_core_direct (
    .a_i(ca), .b_i(cb), .op_i(cop), .res_o(cres)
  );

  function automatic logic [3:0] exp_op(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 4'b0010;
    if (c == 2'b01) return 4'b0110;
    if (c == 2'b10) begin
      case (f)
        6'b100000: return 4'b0010;
        6'b100010: return 4'b0110;
        6'b100100: return 4'b0000;
        6'b100101: return 4'b0001;
        6'b101010: return 4'b0111;
        default: ;
      endcase
    end
    return {1'b0, c[0] | (c[1] & f[1]), ~c[1] | ~f[2], c[1] & (f[3] | f[0])};
  endfunction

  function automatic logic [31:0] exp_res(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    case (o)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return (($signed(x) < $signed(y)) ? 32'd1 : 32'd0);
      4'b1100: return ~(x | y);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f, input logic [31:0] x, input logic [31:0] y, input string tag);
    logic [3:0]  eo;
    logic [31:0] er;
    @(posedge clk);
    cls = c; fn = f; a = x; b = y;
    @(negedge clk);
    eo = exp_op(c, f);
    er = exp_res(eo, x, y);
    check(op == eo, {tag, " op"}, {28'd0, op}, {28'd0, eo});
    check(res == er, {tag, " result"}, res, er);
    check(zero == (er == 32'd0), "R9 zero", {31'd0, zero}, {31'd0, er == 32'd0});
  endtask

  task automatic core(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y, input string tag);
    @(posedge clk);
    cop = o; ca = x; cb = y;
    @(negedge clk);
    check(cres == exp_res(o, x, y), tag, cres, exp_res(o, x, y));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] seed;
    cls = 2'b00; fn = '0; a = '0; b = '0;
    ca = '0; cb = '0; cop = '0;
    seed = $urandom(32'h1d5e);
    @(negedge clk);
    check(op == 4'b0010 && res == 32'd0 && zero, "R1 R9 idle state", {28'd0, op}, 32'd2);

    // R4: exhaustive control table
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 64; f++) begin
        @(posedge clk);
        cls = c[1:0]; fn = f[5:0];
        @(negedge clk);
        check(op == exp_op(c[1:0], f[5:0]), "R4 control", {28'd0, op}, {28'd0, exp_op(c[1:0], f[5:0])});
      end

    apply(2'b00, 6'b101010, 32'd100, 32'd24, "R1 mem add ignores funct");
    apply(2'b01, 6'b100101, 32'd7, 32'd7, "R2 branch sub equal");
    apply(2'b01, 6'b000000, 32'd7, 32'd9, "R2 branch sub unequal");
    apply(2'b10, 6'b100000, 32'h7fffffff, 32'd1, "R3 R5 add wrap");
    apply(2'b10, 6'b100000, 32'hffffffff, 32'd1, "R5 add wrap to zero");
    apply(2'b10, 6'b100010, 32'd0, 32'd1, "R3 R5 sub wrap");
    apply(2'b10, 6'b100100, 32'hf0f0ff00, 32'h0ff0f0f0, "R3 R5 and");
    apply(2'b10, 6'b100101, 32'hf0f00000, 32'h0000000f, "R3 R5 or");
    apply(2'b10, 6'b101010, 32'hffffffff, 32'd0, "R3 R6 slt neg lt");
    apply(2'b10, 6'b101010, 32'd0, 32'hffffffff, "R6 slt false");
    apply(2'b10, 6'b101010, 32'h80000000, 32'h7fffffff, "R6 slt extremes");
    apply(2'b10, 6'b101010, 32'd5, 32'd5, "R6 slt equal");
    apply(2'b10, 6'b001000, 32'h1234, 32'h5678, "R8 unknown code");
    apply(2'b11, 6'b000100, 32'h1234, 32'h5678, "R8 class 11");

    core(4'b1100, 32'hf0f00000, 32'h0000000f, "R7 nor");
    core(4'b1100, 32'd0, 32'd0, "R7 nor all ones");
    core(4'b1111, 32'hffffffff, 32'd3, "R8 core unknown");
    core(4'b0011, 32'hffffffff, 32'd3, "R8 core 0011");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x, y;
      logic [5:0]  f;
      x = $urandom;
      y = ($urandom_range(0, 7) == 0) ? x : $urandom;
      case ($urandom_range(0, 3))
        0: f = 6'b100000;
        1: f = 6'b100010;
        2: f = {4'b1010, 2'b10};
        default: f = $urandom;
      endcase
      apply($urandom_range(0, 3), f, x, y, "R5 random");
    end
    finish_up();
  end
endmodule